// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Byte Codec

The block protects one byte with a 13-bit code word. It has two independent streaming paths. The encode path takes a data byte and returns the 13-bit word. That word holds four even-parity check bits at the power-of-two positions, the eight data bits at the remaining low positions, and an overall parity bit at the top position. The decode path takes a 13-bit word that may have been corrupted. It returns the recovered byte, a 5-bit syndrome, and exactly one of four status flags: clean, data bit repaired, check bit repaired, or uncorrectable.

Each path has one register stage with a valid/ready handshake on both sides. A transfer takes place on a rising clock edge when valid and ready are both high. An input is accepted while the output register is empty or is being drained in that same cycle. An output that is valid but not taken is held stable, and the path then stalls its input. The two paths share only the clock and reset.

Top module: `hsd_codec`

## Requirements
- R1: The code word bit index i holds position i+1. The layout from bit 0 upward is P1, P2, D1, P3, D2, D3, D4, P4, D5, D6, D7, D8, P5, where D1 is data bit 0 and D8 is data bit 7. The check bits use even parity: P1 = D1^D2^D4^D5^D7, P2 = D1^D3^D4^D6^D7, P3 = D2^D3^D4^D8, P4 = D5^D6^D7^D8.
- R2: P5 makes the number of ones in the whole 13-bit word even.
- R3: On both paths, an input accepted at a clock edge appears as a valid output right after that edge, which gives one cycle of latency.
- R4: While an output is valid and its ready is low, the output holds its value and that path's input ready is low.
- R5: A received word with all syndrome bits zero raises the clean flag, and the byte is returned unchanged.
- R6: The syndrome output has S5 (the parity of all 13 received bits) in bit 4. Bits 3:0 hold S4..S1, where Si is the XOR of Pi with the bits that formed it.
- R7: When S5=1 and S4..S1 has two or more bits set with a value of 12 or less, the data bit at that position is flipped and the data-repaired flag is raised.
- R8: When S5=1 and exactly one of S4..S1 is set, a check bit is in error. When S5=1 and S4..S1 is zero, P5 is in error. In both cases the check-repaired flag is raised and the returned byte equals the sent byte.
- R9: When S5=0 and S4..S1 is nonzero, the uncorrectable flag is raised, and the byte is taken from the received word with no bit flipped.
- R10: When S5=1 and S4..S1 is 13 to 15, the word is treated as uncorrectable in the same way as R9.
- R11: During reset both output valids are low, and after reset both input readies are high.
- R12: While the decode output is valid, exactly one of the four flags is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_in_valid | input | 1 | Byte offered to the encoder |
| enc_in_ready | output | 1 | Encoder can take a byte |
| enc_in_data | input | 8 | Byte to encode |
| enc_out_valid | output | 1 | Code word available |
| enc_out_ready | input | 1 | Consumer takes the code word |
| enc_out_cw | output | 13 | Encoded word |
| dec_in_valid | input | 1 | Word offered to the decoder |
| dec_in_ready | output | 1 | Decoder can take a word |
| dec_in_cw | input | 13 | Received word |
| dec_out_valid | output | 1 | Decode result available |
| dec_out_ready | input | 1 | Consumer takes the result |
| dec_out_data | output | 8 | Recovered byte |
| dec_out_syn | output | 5 | {S5, S4, S3, S2, S1} |
| dec_out_ok | output | 1 | No error seen |
| dec_out_fix_data | output | 1 | One data bit repaired |
| dec_out_fix_chk | output | 1 | One check bit or P5 repaired |
| dec_out_dbl | output | 1 | Uncorrectable error |

## Verification
Every result of both paths is due one clock edge after its input is accepted. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples all outputs at the next falling edge. The stall test holds ready low across one more edge and samples again on the following falling edge, to confirm that the word has not moved. Each vector is then drained by one further edge before the next one is driven.

// File: rtl/hsd_pkg.sv
package hsd_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN     = 2'd0,
    ST_FIX_DATA  = 2'd1,
    ST_FIX_CHECK = 2'd2,
    ST_UNCORR    = 2'd3
  } hsd_status_e;

  // smallest r with 2^r >= k + r + 1 (single-error location)
  function automatic int unsigned chk_bits(input int unsigned k);
    int unsigned r;
    r = 1;
    while ((1 << r) < (k + r + 1)) r++;
    return r;
  endfunction

  function automatic logic is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/hsd_encoder.sv
module hsd_encoder #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CHK_W   = hsd_pkg::chk_bits(DATA_W),
  localparam int unsigned INNER_W = DATA_W + CHK_W,
  localparam int unsigned CW_W    = INNER_W + 1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   cw_o
);
  localparam int unsigned DI_W = $clog2(DATA_W);
  localparam int unsigned PI_W = $clog2(INNER_W + 1);

  logic [INNER_W:1] pos;
  int unsigned      didx;
  logic             par;

  always_comb begin
    pos  = '0;
    didx = 0;
    // data fills the non-power-of-two positions from low to high
    for (int unsigned p = 1; p <= INNER_W; p++) begin
      if (!hsd_pkg::is_pow2(p)) begin
        pos[PI_W'(p)] = data_i[DI_W'(didx)];
        didx++;
      end
    end
    // check bit j covers every position whose index has bit j set
    for (int unsigned j = 0; j < CHK_W; j++) begin
      par = 1'b0;
      for (int unsigned p = 1; p <= INNER_W; p++) begin
        if (((p >> j) & 1) != 0) par ^= pos[PI_W'(p)];
      end
      pos[PI_W'(1 << j)] = par;
    end
    cw_o = {^pos, pos};
  end

endmodule

// File: rtl/hsd_syndrome.sv
module hsd_syndrome #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CHK_W   = hsd_pkg::chk_bits(DATA_W),
  localparam int unsigned INNER_W = DATA_W + CHK_W,
  localparam int unsigned CW_W    = INNER_W + 1
) (
  input  logic [CW_W-1:0]          cw_i,
  output logic [CHK_W-1:0]         syn_o,
  output logic                     s_all_o,
  output hsd_pkg::hsd_status_e     status_o
);
  import hsd_pkg::*;

  localparam int unsigned CI_W = $clog2(CW_W);
  localparam int unsigned SJ_W = (CHK_W > 1) ? $clog2(CHK_W) : 1;

  logic multi;

  always_comb begin
    syn_o = '0;
    for (int unsigned j = 0; j < CHK_W; j++) begin
      for (int unsigned p = 1; p <= INNER_W; p++) begin
        if (((p >> j) & 1) != 0) syn_o[SJ_W'(j)] ^= cw_i[CI_W'(p - 1)];
      end
    end
  end

  assign s_all_o = ^cw_i;
  assign multi   = (syn_o & (syn_o - 1'b1)) != '0;

  always_comb begin
    if (!s_all_o) begin
      status_o = (syn_o == '0) ? ST_CLEAN : ST_UNCORR;
    end else if (!multi) begin
      status_o = ST_FIX_CHECK;               // top parity or a single check bit
    end else if (syn_o <= CHK_W'(INNER_W)) begin
      status_o = ST_FIX_DATA;
    end else begin
      status_o = ST_UNCORR;                  // points past the last position
    end
  end

endmodule

// File: rtl/hsd_corrector.sv
module hsd_corrector #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CHK_W   = hsd_pkg::chk_bits(DATA_W),
  localparam int unsigned INNER_W = DATA_W + CHK_W,
  localparam int unsigned CW_W    = INNER_W + 1
) (
  input  logic [CW_W-1:0]   cw_i,
  input  logic [CHK_W-1:0]  syn_i,
  input  logic              fix_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned CI_W = $clog2(CW_W);
  localparam int unsigned DI_W = $clog2(DATA_W);

  logic [CW_W-1:0] fixed;
  int unsigned     didx;

  always_comb begin
    fixed = cw_i;
    if (fix_i && (syn_i == '0)) fixed[CW_W-1] = ~cw_i[CW_W-1];
    for (int unsigned p = 1; p <= INNER_W; p++) begin
      if (fix_i && (syn_i == CHK_W'(p))) fixed[CI_W'(p - 1)] = ~cw_i[CI_W'(p - 1)];
    end
  end

  always_comb begin
    data_o = '0;
    didx   = 0;
    for (int unsigned p = 1; p <= INNER_W; p++) begin
      if (!hsd_pkg::is_pow2(p)) begin
        data_o[DI_W'(didx)] = fixed[CI_W'(p - 1)];
        didx++;
      end
    end
  end

endmodule

// File: rtl/hsd_pipe_reg.sv
module hsd_pipe_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);
  assign in_ready_o = !out_valid_o || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else if (in_valid_i && in_ready_o) begin
      out_valid_o <= 1'b1;
      out_data_o  <= in_data_i;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  // R3: accepted input is presented on the next cycle
  a_r3_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  // R4: a stalled output neither drops nor changes
  a_r4_hold_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

endmodule

// File: rtl/hsd_codec.sv
module hsd_codec #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CHK_W   = hsd_pkg::chk_bits(DATA_W),
  localparam int unsigned INNER_W = DATA_W + CHK_W,
  localparam int unsigned CW_W    = INNER_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_in_valid,
  output logic              enc_in_ready,
  input  logic [DATA_W-1:0] enc_in_data,
  output logic              enc_out_valid,
  input  logic              enc_out_ready,
  output logic [CW_W-1:0]   enc_out_cw,
  input  logic              dec_in_valid,
  output logic              dec_in_ready,
  input  logic [CW_W-1:0]   dec_in_cw,
  output logic              dec_out_valid,
  input  logic              dec_out_ready,
  output logic [DATA_W-1:0] dec_out_data,
  output logic [CHK_W:0]    dec_out_syn,
  output logic              dec_out_ok,
  output logic              dec_out_fix_data,
  output logic              dec_out_fix_chk,
  output logic              dec_out_dbl
);
  import hsd_pkg::*;

  localparam int unsigned DEC_W = DATA_W + CHK_W + 1 + 2;

  // encode path
  logic [CW_W-1:0] enc_cw;

  hsd_encoder #(.DATA_W(DATA_W)) enc_u (
    .data_i (enc_in_data),
    .cw_o   (enc_cw)
  );

  hsd_pipe_reg #(.W(CW_W)) enc_stage_u (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (enc_in_valid),
    .in_ready_o  (enc_in_ready),
    .in_data_i   (enc_cw),
    .out_valid_o (enc_out_valid),
    .out_ready_i (enc_out_ready),
    .out_data_o  (enc_out_cw)
  );

  // decode path
  logic [CHK_W-1:0]  syn;
  logic              s_all;
  hsd_status_e       status;
  logic [DATA_W-1:0] dec_data;
  logic [DEC_W-1:0]  dec_q;
  hsd_status_e       status_q;

  hsd_syndrome #(.DATA_W(DATA_W)) syn_u (
    .cw_i     (dec_in_cw),
    .syn_o    (syn),
    .s_all_o  (s_all),
    .status_o (status)
  );

  hsd_corrector #(.DATA_W(DATA_W)) fix_u (
    .cw_i   (dec_in_cw),
    .syn_i  (syn),
    .fix_i  ((status == ST_FIX_DATA) || (status == ST_FIX_CHECK)),
    .data_o (dec_data)
  );

  hsd_pipe_reg #(.W(DEC_W)) dec_stage_u (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (dec_in_valid),
    .in_ready_o  (dec_in_ready),
    .in_data_i   ({dec_data, s_all, syn, status}),
    .out_valid_o (dec_out_valid),
    .out_ready_i (dec_out_ready),
    .out_data_o  (dec_q)
  );

  assign status_q         = hsd_status_e'(dec_q[1:0]);
  assign dec_out_syn      = dec_q[CHK_W+2:2];
  assign dec_out_data     = dec_q[DEC_W-1:CHK_W+3];
  assign dec_out_ok       = (status_q == ST_CLEAN);
  assign dec_out_fix_data = (status_q == ST_FIX_DATA);
  assign dec_out_fix_chk  = (status_q == ST_FIX_CHECK);
  assign dec_out_dbl      = (status_q == ST_UNCORR);

  // R2: every emitted word has even weight
  a_r2_even_word: assert property (@(posedge clk) disable iff (!rst_n)
    enc_out_valid |-> (^enc_out_cw == 1'b0));

  // R12: one status flag per result
  a_r12_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    dec_out_valid |-> $onehot({dec_out_ok, dec_out_fix_data, dec_out_fix_chk, dec_out_dbl}));

  // R5: clean only with an all-zero syndrome
  a_r5_clean_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_out_valid && dec_out_ok) |-> (dec_out_syn == '0));

  // R8: syndrome pointing at the top parity bit is a check repair
  a_r8_top_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_out_valid && (dec_out_syn == {1'b1, {CHK_W{1'b0}}})) |-> dec_out_fix_chk);

  // R9 and R10: uncorrectable only for even-weight errors or out-of-range pointers
  a_r9_uncorr_cases: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_out_valid && dec_out_dbl) |->
      ((!dec_out_syn[CHK_W] && (dec_out_syn[CHK_W-1:0] != '0)) ||
       (dec_out_syn[CHK_W] && (dec_out_syn[CHK_W-1:0] > CHK_W'(INNER_W)))));

endmodule

// File: tb/hsd_codec_tb.sv
`timescale 1ns/1ps
module hsd_codec_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_in_valid = 1'b0;
  logic        enc_in_ready;
  logic [7:0]  enc_in_data = '0;
  logic        enc_out_valid;
  logic        enc_out_ready = 1'b1;
  logic [12:0] enc_out_cw;
  logic        dec_in_valid = 1'b0;
  logic        dec_in_ready;
  logic [12:0] dec_in_cw = '0;
  logic        dec_out_valid;
  logic        dec_out_ready = 1'b1;
  logic [7:0]  dec_out_data;
  logic [4:0]  dec_out_syn;
  logic        dec_out_ok, dec_out_fix_data, dec_out_fix_chk, dec_out_dbl;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hsd_codec dut_i (
    .clk(clk), .rst_n(rst_n),
    .enc_in_valid(enc_in_valid), .enc_in_ready(enc_in_ready), .enc_in_data(enc_in_data),
    .enc_out_valid(enc_out_valid), .enc_out_ready(enc_out_ready), .enc_out_cw(enc_out_cw),
    .dec_in_valid(dec_in_valid), .dec_in_ready(dec_in_ready), .dec_in_cw(dec_in_cw),
    .dec_out_valid(dec_out_valid), .dec_out_ready(dec_out_ready), .dec_out_data(dec_out_data),
    .dec_out_syn(dec_out_syn), .dec_out_ok(dec_out_ok), .dec_out_fix_data(dec_out_fix_data),
    .dec_out_fix_chk(dec_out_fix_chk), .dec_out_dbl(dec_out_dbl)
  );

  // {data, flip mask (bit i = position i+1), class: 0 clean 1 data fix 2 check fix 3 uncorrectable}
  localparam int NV = 13;
  localparam logic [22:0] VEC [NV] = '{
    {8'h00, 13'h0000, 2'd0},
    {8'hFF, 13'h0000, 2'd0},
    {8'hA5, 13'h0000, 2'd0},
    {8'h5A, 13'h0004, 2'd1},
    {8'h3C, 13'h0800, 2'd1},
    {8'h81, 13'h0040, 2'd1},
    {8'h7E, 13'h0100, 2'd1},
    {8'hC3, 13'h0001, 2'd2},
    {8'h96, 13'h0080, 2'd2},
    {8'h69, 13'h1000, 2'd2},
    {8'h12, 13'h0014, 2'd3},
    {8'h34, 13'h1001, 2'd3},
    {8'hE7, 13'h0089, 2'd3}
  };

  function automatic logic [12:0] ref_enc(input logic [7:0] x);
    logic p1, p2, p3, p4, p5;
    p1 = x[0] ^ x[1] ^ x[3] ^ x[4] ^ x[6];
    p2 = x[0] ^ x[2] ^ x[3] ^ x[5] ^ x[6];
    p3 = x[1] ^ x[2] ^ x[3] ^ x[7];
    p4 = x[4] ^ x[5] ^ x[6] ^ x[7];
    p5 = (^x) ^ p1 ^ p2 ^ p3 ^ p4;
    return {p5, x[7], x[6], x[5], x[4], p4, x[3], x[2], x[1], p3, x[0], p2, p1};
  endfunction

  function automatic logic [7:0] ref_extract(input logic [12:0] w);
    return {w[11], w[10], w[9], w[8], w[6], w[5], w[4], w[2]};
  endfunction

  function automatic logic [4:0] ref_syn(input logic [12:0] m);
    logic [3:0] s;
    s = 4'd0;
    for (int p = 1; p <= 12; p++) if (m[p-1]) s ^= 4'(p);
    return {^m, s};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input int i);
    logic [7:0]  d;
    logic [12:0] m;
    logic [1:0]  c;
    logic [12:0] good;
    {d, m, c} = VEC[i];
    good = ref_enc(d);
    @(negedge clk);
    enc_in_valid = 1'b1; enc_in_data = d;
    dec_in_valid = 1'b1; dec_in_cw = good ^ m;
    @(negedge clk);
    enc_in_valid = 1'b0; dec_in_valid = 1'b0;
    chk("R3 enc valid after one edge", 32'(enc_out_valid), 32'd1);
    chk("R1 R2 code word", 32'(enc_out_cw), 32'(good));
    chk("R3 dec valid after one edge", 32'(dec_out_valid), 32'd1);
    chk("R6 syndrome", 32'(dec_out_syn), 32'(ref_syn(m)));
    chk((c == 2'd0) ? "R5 flags" : (c == 2'd1) ? "R7 flags" : (c == 2'd2) ? "R8 flags" : "R9 R10 flags",
        32'({dec_out_ok, dec_out_fix_data, dec_out_fix_chk, dec_out_dbl}), 32'(4'b1000 >> c));
    chk("R12 one flag", 32'($countones({dec_out_ok, dec_out_fix_data, dec_out_fix_chk, dec_out_dbl})), 32'd1);
    chk((c == 2'd3) ? "R9 uncorrected data" : "R7 R8 data",
        32'(dec_out_data), (c == 2'd3) ? 32'(ref_extract(good ^ m)) : 32'(d));
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 enc valid in reset", 32'(enc_out_valid), 32'd0);
    chk("R11 dec valid in reset", 32'(dec_out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 enc ready after reset", 32'(enc_in_ready), 32'd1);
    chk("R11 dec ready after reset", 32'(dec_in_ready), 32'd1);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R4: stall the encoder output and offer a second byte
    @(negedge clk);
    enc_out_ready = 1'b0;
    enc_in_valid = 1'b1; enc_in_data = 8'h4D;
    @(negedge clk);
    enc_in_data = 8'hB2;
    chk("R4 ready low while stalled", 32'(enc_in_ready), 32'd0);
    chk("R4 first word present", 32'(enc_out_cw), 32'(ref_enc(8'h4D)));
    @(negedge clk);
    chk("R4 held valid", 32'(enc_out_valid), 32'd1);
    chk("R4 held word", 32'(enc_out_cw), 32'(ref_enc(8'h4D)));
    enc_out_ready = 1'b1;
    @(negedge clk);
    enc_in_valid = 1'b0;
    chk("R4 second word after release", 32'(enc_out_cw), 32'(ref_enc(8'hB2)));
    @(negedge clk);
    chk("R3 output drained", 32'(enc_out_valid), 32'd0);

    // R4 on the decode path
    dec_out_ready = 1'b0;
    dec_in_valid = 1'b1; dec_in_cw = ref_enc(8'h11) ^ 13'h0200;
    @(negedge clk);
    dec_in_cw = ref_enc(8'h22);
    chk("R4 dec ready low while stalled", 32'(dec_in_ready), 32'd0);
    @(negedge clk);
    chk("R4 dec held data", 32'(dec_out_data), 32'h11);
    chk("R4 dec held flag", 32'(dec_out_fix_data), 32'd1);
    dec_out_ready = 1'b1;
    @(negedge clk);
    dec_in_valid = 1'b0;
    chk("R5 dec second result", 32'({dec_out_data, dec_out_ok}), 32'({8'h22, 1'b1}));
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule